// File: doc/BRIEF.md
# ADC Conversion Group Sequencer

This block is the digital side of a multi-channel analog-to-digital converter. It keeps two channel lists: a regular list of up to nine ranks and a higher-priority inserted list of up to four ranks. It drives an external converter through a one-cycle start pulse and a channel number, then waits for a done pulse that carries the result word. Each list is launched by a software start bit or by an edge on its own external trigger input. Scan, continuous, discontinuous and auto-inserted modes decide how many ranks one launch converts and what runs next.

Regular results land in one shared data register. Inserted results land in one register per inserted rank. Five sticky status flags report events: end of conversion, end of inserted group, regular start, inserted start and regular overrun. Each flag has an interrupt enable that gates its line. A write-only register port loads the control word, the list lengths and the channel tables, and clears status flags.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset all status flags, interrupt lines, the regular data register, the inserted data registers and the start output are zero, and no conversion is issued until a launch occurs.
- R2: With scan off (control bit 0 clear), one launch converts only rank 0 of the launched list and then stops.
- R3: With scan on, a regular launch converts ranks 0 up to the programmed length in order. The length is written as length minus one in bits [3:0] of address 1, and a value above 8 leaves the stored length unchanged. Rank k's channel is written at address 8+k, bits [4:0].
- R4: Inserted length minus one sits in bits [5:4] of address 1, and slot j's channel is at address 4+j. Conversion starts at slot 3 minus that value and runs through slot 3. The result of the n-th inserted rank goes to inj_data bits [16n+15:16n], and status bit 1 sets when the last inserted rank completes.
- R5: At most one conversion is outstanding at a time. An inserted launch during a regular sequence is converted right after the conversion in flight, and the regular list then continues at its next rank.
- R6: With regular discontinuous mode on (control bit 2), each launch converts the next chunk of ranks. The chunk size minus one sits in control bits [9:7]. The position is kept between launches and wraps to rank 0 after the last rank.
- R7: With inserted discontinuous mode on (control bit 3), each inserted launch converts a single inserted rank, and status bit 1 sets only after the last one.
- R8: With continuous mode on (control bit 1), the regular list restarts at rank 0 after its last rank without a new launch. Clearing the bit lets the list finish at its last rank and stop.
- R9: With auto-inserted mode on (control bit 4), completing the regular list launches the inserted list with no inserted trigger.
- R10: Each list has a 2-bit edge select: control bits [11:10] for regular and [13:12] for inserted. The codes are 0 = off, 1 = rising, 2 = falling, 3 = both edges. A control write with bit 14 (regular) or bit 15 (inserted) set launches that list.
- R11: With control bit 5 set, status bit 0 sets after every regular result, and a result written while bit 0 is still set raises overrun (status bit 4). With bit 5 clear, bit 0 sets only at the end of the regular list, and overrun is raised only if control bit 6 is set.
- R12: Status bit 2 sets when a regular launch begins, and status bit 3 sets when an inserted launch begins.
- R13: A write to address 2 clears every status bit whose data bit is 0 and keeps those written 1. Interrupt line i equals status bit i AND enable bit i, and the enables sit in control bits [20:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| ext_trig_reg | input | 1 | External trigger level for the regular list |
| ext_trig_inj | input | 1 | External trigger level for the inserted list |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | CH_W | Channel to convert, valid with conv_start |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | DATA_W | Result word, valid with conv_done |
| reg_data | output | DATA_W | Latest regular result |
| inj_data | output | INJ_RANKS*DATA_W | Inserted results, one field per rank |
| status | output | 5 | Sticky flags: 0 end of conversion, 1 end of inserted group, 2 regular start, 3 inserted start, 4 overrun |
| irq | output | 5 | Status flags gated by their enables |

## Verification
The sequencer is driven by software starts, by each external edge code with the level held and then released, and by mode mixes: scan off, full scans, chunked and single-rank discontinuous launches, continuous running then stopped, and auto-inserted chaining. These patterns show whether the position counter wraps or stops in the right place and whether a launch is taken or ignored. An inserted launch timed to land inside a long regular conversion checks that priority takes effect at a conversion boundary and not earlier. Seeded random list lengths and channel tables compare the issued channel order and the final result with a model in the bench. The overrun cases separate the per-result and per-list flag modes, with and without the DMA-style override.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NFLAGS  = 5;
  localparam int FLG_EOC = 0;
  localparam int FLG_EOI = 1;
  localparam int FLG_RST = 2;
  localparam int FLG_IST = 3;
  localparam int FLG_OVF = 4;

  typedef enum logic [1:0] {EDGE_OFF, EDGE_RISE, EDGE_FALL, EDGE_BOTH} edge_t;

  typedef struct packed {
    logic              scan;
    logic              cont;
    logic              disc_reg;
    logic              disc_inj;
    logic              auto_inj;
    logic              eoc_each;
    logic              dma_mode;
    logic [2:0]        disc_m1;
    logic [1:0]        reg_edge;
    logic [1:0]        inj_edge;
    logic [NFLAGS-1:0] irq_en;
  } ctrl_t;
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sig,
  input  logic [1:0] mode,
  output logic       hit
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sig;
  end

  always_comb begin
    case (edge_t'(mode))
      EDGE_RISE: hit = sig & ~prev;
      EDGE_FALL: hit = ~sig & prev;
      EDGE_BOTH: hit = sig ^ prev;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CH_W      = 5,
  parameter int REG_RANKS = 9,
  parameter int INJ_RANKS = 4,
  localparam int RL_W = $clog2(REG_RANKS),
  localparam int IL_W = $clog2(INJ_RANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output ctrl_t             ctrl,
  output logic [RL_W-1:0]   reg_len_m1,
  output logic [IL_W-1:0]   inj_len_m1,
  output logic              sw_reg,
  output logic              sw_inj,
  output logic              stat_wr,
  output logic [NFLAGS-1:0] stat_wdata,
  input  logic [RL_W-1:0]   reg_rd_idx,
  output logic [CH_W-1:0]   reg_rd_chan,
  input  logic [IL_W-1:0]   inj_rd_idx,
  output logic [CH_W-1:0]   inj_rd_chan
);
  localparam int A_CTRL = 0;
  localparam int A_LEN  = 1;
  localparam int A_STAT = 2;
  localparam int A_INJ  = 4;
  localparam int A_REG  = 8;

  logic [CH_W-1:0]   reg_tab [REG_RANKS];
  logic [CH_W-1:0]   inj_tab [INJ_RANKS];
  logic [ADDR_W-1:0] reg_off, inj_off;
  logic              is_ctrl, is_len, is_reg, is_inj;
  logic              unused_hi;

  assign unused_hi = ^wr_data[31:21];
  assign is_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign is_len  = wr_en && (wr_addr == ADDR_W'(A_LEN));
  assign stat_wr = wr_en && (wr_addr == ADDR_W'(A_STAT));
  assign reg_off = wr_addr - ADDR_W'(A_REG);
  assign inj_off = wr_addr - ADDR_W'(A_INJ);
  assign is_reg  = wr_en && (wr_addr >= ADDR_W'(A_REG)) && (wr_addr < ADDR_W'(A_REG + REG_RANKS));
  assign is_inj  = wr_en && (wr_addr >= ADDR_W'(A_INJ)) && (wr_addr < ADDR_W'(A_INJ + INJ_RANKS));
  assign sw_reg     = is_ctrl && wr_data[14];
  assign sw_inj     = is_ctrl && wr_data[15];
  assign stat_wdata = wr_data[NFLAGS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl       <= '0;
      reg_len_m1 <= '0;
      inj_len_m1 <= '0;
    end else begin
      if (is_ctrl) begin
        ctrl.scan     <= wr_data[0];
        ctrl.cont     <= wr_data[1];
        ctrl.disc_reg <= wr_data[2];
        ctrl.disc_inj <= wr_data[3];
        ctrl.auto_inj <= wr_data[4];
        ctrl.eoc_each <= wr_data[5];
        ctrl.dma_mode <= wr_data[6];
        ctrl.disc_m1  <= wr_data[9:7];
        ctrl.reg_edge <= wr_data[11:10];
        ctrl.inj_edge <= wr_data[13:12];
        ctrl.irq_en   <= wr_data[16 +: NFLAGS];
      end
      if (is_len) begin
        if (wr_data[RL_W-1:0] <= RL_W'(REG_RANKS - 1))
          reg_len_m1 <= wr_data[RL_W-1:0];
        inj_len_m1 <= wr_data[RL_W +: IL_W];
      end
    end
  end

  // channel tables carry no reset so they map onto distributed RAM
  always_ff @(posedge clk) begin
    if (is_reg) reg_tab[reg_off[RL_W-1:0]] <= wr_data[CH_W-1:0];
    if (is_inj) inj_tab[inj_off[IL_W-1:0]] <= wr_data[CH_W-1:0];
  end

  assign reg_rd_chan = reg_tab[reg_rd_idx];
  assign inj_rd_chan = inj_tab[inj_rd_idx];
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core #(
  parameter int CH_W      = 5,
  parameter int DATA_W    = 16,
  parameter int REG_RANKS = 9,
  parameter int INJ_RANKS = 4,
  localparam int RL_W = $clog2(REG_RANKS),
  localparam int IL_W = $clog2(INJ_RANKS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        scan,
  input  logic                        cont,
  input  logic                        disc_reg,
  input  logic                        disc_inj,
  input  logic                        auto_inj,
  input  logic [2:0]                  disc_m1,
  input  logic [RL_W-1:0]             reg_len_m1,
  input  logic [IL_W-1:0]             inj_len_m1,
  input  logic                        reg_trig,
  input  logic                        inj_trig,
  output logic [RL_W-1:0]             reg_rd_idx,
  input  logic [CH_W-1:0]             reg_rd_chan,
  output logic [IL_W-1:0]             inj_rd_idx,
  input  logic [CH_W-1:0]             inj_rd_chan,
  output logic                        conv_start,
  output logic [CH_W-1:0]             conv_chan,
  input  logic                        conv_done,
  input  logic [DATA_W-1:0]           conv_result,
  output logic [DATA_W-1:0]           reg_data,
  output logic [INJ_RANKS*DATA_W-1:0] inj_data,
  output logic                        ev_reg_start,
  output logic                        ev_inj_start,
  output logic                        ev_reg_done,
  output logic                        ev_reg_end,
  output logic                        ev_inj_end
);
  logic              busy_q, grp_inj_q;
  logic              reg_run, inj_run;
  logic [RL_W-1:0]   reg_idx;
  logic [IL_W-1:0]   inj_rank;
  logic [2:0]        burst;
  logic              done_reg, done_inj, reg_last, inj_last, reg_go, inj_go;
  logic [DATA_W-1:0] inj_mem [INJ_RANKS];

  assign done_reg = busy_q & conv_done & ~grp_inj_q;
  assign done_inj = busy_q & conv_done & grp_inj_q;
  assign reg_last = ~scan | (reg_idx >= reg_len_m1);
  assign inj_last = ~scan | (inj_rank >= inj_len_m1);
  assign reg_go   = reg_trig & ~reg_run;
  assign inj_go   = (inj_trig | (done_reg & reg_last & auto_inj)) & ~inj_run;

  assign reg_rd_idx = reg_idx;
  // short inserted lists occupy the top slots of the table
  assign inj_rd_idx = IL_W'(INJ_RANKS - 1) - inj_len_m1 + inj_rank;

  assign ev_reg_start = reg_go;
  assign ev_inj_start = inj_go;
  assign ev_reg_done  = done_reg;
  assign ev_reg_end   = done_reg & reg_last;
  assign ev_inj_end   = done_inj & inj_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      grp_inj_q  <= 1'b0;
      reg_run    <= 1'b0;
      inj_run    <= 1'b0;
      reg_idx    <= '0;
      inj_rank   <= '0;
      burst      <= '0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      reg_data   <= '0;
    end else begin
      conv_start <= 1'b0;
      if (reg_go) reg_run <= 1'b1;
      if (inj_go) inj_run <= 1'b1;
      if (done_reg) begin
        busy_q   <= 1'b0;
        reg_data <= conv_result;
        if (reg_last) begin
          reg_idx <= '0;
          burst   <= '0;
          if (!cont) reg_run <= 1'b0;
        end else begin
          reg_idx <= reg_idx + 1'b1;
          if (disc_reg && burst == disc_m1) begin
            reg_run <= 1'b0;
            burst   <= '0;
          end else begin
            burst <= burst + 1'b1;
          end
        end
      end
      if (done_inj) begin
        busy_q <= 1'b0;
        if (inj_last) begin
          inj_rank <= '0;
          inj_run  <= 1'b0;
        end else begin
          inj_rank <= inj_rank + 1'b1;
          if (disc_inj) inj_run <= 1'b0;
        end
      end
      if (!busy_q) begin
        if (inj_run) begin
          busy_q     <= 1'b1;
          grp_inj_q  <= 1'b1;
          conv_start <= 1'b1;
          conv_chan  <= inj_rd_chan;
        end else if (reg_run) begin
          busy_q     <= 1'b1;
          grp_inj_q  <= 1'b0;
          conv_start <= 1'b1;
          conv_chan  <= reg_rd_chan;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < INJ_RANKS; i++) inj_mem[i] <= '0;
    end else if (done_inj) begin
      inj_mem[inj_rank] <= conv_result;
    end
  end

  for (genvar g = 0; g < INJ_RANKS; g++) begin : g_inj_out
    assign inj_data[g*DATA_W +: DATA_W] = inj_mem[g];
  end

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  p_one_in_flight_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !conv_done) |=> !conv_start);
  p_reg_run_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_run) |-> $past(reg_trig));
endmodule

// File: rtl/adc_seq_flags.sv
module adc_seq_flags
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_reg_start,
  input  logic              ev_inj_start,
  input  logic              ev_reg_done,
  input  logic              ev_reg_end,
  input  logic              ev_inj_end,
  input  logic              eoc_each,
  input  logic              dma_mode,
  input  logic              stat_wr,
  input  logic [NFLAGS-1:0] stat_wdata,
  input  logic [NFLAGS-1:0] irq_en,
  output logic [NFLAGS-1:0] status,
  output logic [NFLAGS-1:0] irq
);
  logic [NFLAGS-1:0] set_v, nxt;

  always_comb begin
    set_v          = '0;
    set_v[FLG_EOC] = ev_reg_done & (eoc_each | ev_reg_end);
    set_v[FLG_EOI] = ev_inj_end;
    set_v[FLG_RST] = ev_reg_start;
    set_v[FLG_IST] = ev_inj_start;
    set_v[FLG_OVF] = ev_reg_done & status[FLG_EOC] & (eoc_each | dma_mode);
    nxt = status;
    if (stat_wr) nxt = nxt & stat_wdata;
    nxt = nxt | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= '0;
    end else begin
      status <= nxt;
      irq    <= nxt & irq_en;
    end
  end

  p_ovf_cause_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(status[FLG_OVF]) |-> $past(ev_reg_done && status[FLG_EOC]));
  p_eoi_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(status[FLG_EOI]) |-> $past(ev_inj_end));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CH_W      = 5,
  parameter int DATA_W    = 16,
  parameter int REG_RANKS = 9,
  parameter int INJ_RANKS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [31:0]                 wr_data,
  input  logic                        ext_trig_reg,
  input  logic                        ext_trig_inj,
  output logic                        conv_start,
  output logic [CH_W-1:0]             conv_chan,
  input  logic                        conv_done,
  input  logic [DATA_W-1:0]           conv_result,
  output logic [DATA_W-1:0]           reg_data,
  output logic [INJ_RANKS*DATA_W-1:0] inj_data,
  output logic [NFLAGS-1:0]           status,
  output logic [NFLAGS-1:0]           irq
);
  localparam int RL_W = $clog2(REG_RANKS);
  localparam int IL_W = $clog2(INJ_RANKS);

  ctrl_t             ctrl;
  logic [RL_W-1:0]   reg_len_m1, reg_rd_idx;
  logic [IL_W-1:0]   inj_len_m1, inj_rd_idx;
  logic [CH_W-1:0]   reg_rd_chan, inj_rd_chan;
  logic              sw_reg, sw_inj, stat_wr;
  logic [NFLAGS-1:0] stat_wdata;
  logic [1:0]        trig_sig, trig_hit;
  logic [1:0]        trig_mode [2];
  logic              ev_reg_start, ev_inj_start, ev_reg_done, ev_reg_end, ev_inj_end;

  adc_seq_regs #(
    .ADDR_W(ADDR_W), .CH_W(CH_W), .REG_RANKS(REG_RANKS), .INJ_RANKS(INJ_RANKS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl), .reg_len_m1(reg_len_m1), .inj_len_m1(inj_len_m1),
    .sw_reg(sw_reg), .sw_inj(sw_inj), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .reg_rd_idx(reg_rd_idx), .reg_rd_chan(reg_rd_chan),
    .inj_rd_idx(inj_rd_idx), .inj_rd_chan(inj_rd_chan)
  );

  assign trig_sig     = {ext_trig_inj, ext_trig_reg};
  assign trig_mode[0] = ctrl.reg_edge;
  assign trig_mode[1] = ctrl.inj_edge;

  for (genvar g = 0; g < 2; g++) begin : g_trig
    adc_seq_trig u_trig (
      .clk(clk), .rst(rst), .sig(trig_sig[g]), .mode(trig_mode[g]), .hit(trig_hit[g])
    );
  end

  adc_seq_core #(
    .CH_W(CH_W), .DATA_W(DATA_W), .REG_RANKS(REG_RANKS), .INJ_RANKS(INJ_RANKS)
  ) u_core (
    .clk(clk), .rst(rst),
    .scan(ctrl.scan), .cont(ctrl.cont), .disc_reg(ctrl.disc_reg),
    .disc_inj(ctrl.disc_inj), .auto_inj(ctrl.auto_inj), .disc_m1(ctrl.disc_m1),
    .reg_len_m1(reg_len_m1), .inj_len_m1(inj_len_m1),
    .reg_trig(trig_hit[0] | sw_reg), .inj_trig(trig_hit[1] | sw_inj),
    .reg_rd_idx(reg_rd_idx), .reg_rd_chan(reg_rd_chan),
    .inj_rd_idx(inj_rd_idx), .inj_rd_chan(inj_rd_chan),
    .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_result(conv_result),
    .reg_data(reg_data), .inj_data(inj_data),
    .ev_reg_start(ev_reg_start), .ev_inj_start(ev_inj_start),
    .ev_reg_done(ev_reg_done), .ev_reg_end(ev_reg_end), .ev_inj_end(ev_inj_end)
  );

  adc_seq_flags u_flags (
    .clk(clk), .rst(rst),
    .ev_reg_start(ev_reg_start), .ev_inj_start(ev_inj_start),
    .ev_reg_done(ev_reg_done), .ev_reg_end(ev_reg_end), .ev_inj_end(ev_inj_end),
    .eoc_each(ctrl.eoc_each), .dma_mode(ctrl.dma_mode),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .irq_en(ctrl.irq_en),
    .status(status), .irq(irq)
  );
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int A_CTRL = 0, A_LEN = 1, A_STAT = 2, A_INJ = 4, A_REG = 8;
  localparam int SCAN = 1, CONT = 2, DREG = 4, DINJ = 8, AUTO = 16, EOCE = 32, DMA = 64;
  localparam int SWR = 1 << 14, SWI = 1 << 15;

  logic        clk = 1'b0, rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        ext_trig_reg = 1'b0, ext_trig_inj = 1'b0;
  logic        conv_start, conv_done = 1'b0;
  logic [4:0]  conv_chan;
  logic [15:0] conv_result = '0, reg_data;
  logic [63:0] inj_data;
  logic [4:0]  status, irq;

  int n_chk = 0, n_err = 0, n_log = 0, lat = 2, serial = 0;
  logic [4:0] log_ch [1024];
  logic [4:0] exp_ch [16];
  bit finished = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_trig_reg(ext_trig_reg), .ext_trig_inj(ext_trig_inj),
    .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_result(conv_result),
    .reg_data(reg_data), .inj_data(inj_data), .status(status), .irq(irq)
  );

  // converter model: done pulse lat cycles after the start pulse
  int cnt = 0;
  logic [4:0] cur_ch = '0;
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (!rst) begin
      if (cnt != 0) begin
        cnt = cnt - 1;
        if (cnt == 0) begin
          conv_done   = 1'b1;
          conv_result = {3'b0, cur_ch, serial[7:0]};
          serial      = serial + 1;
        end
      end
      if (conv_start) begin
        log_ch[n_log] = conv_chan;
        n_log  = n_log + 1;
        cur_ch = conv_chan;
        cnt    = lat;
      end
    end
  end

  function automatic logic [15:0] res(input int k, input logic [4:0] ch);
    return {3'b0, ch, k[7:0]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[4:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_seq(input string req, input int base, input int n);
    check({req, " count"}, n_log - base, n);
    for (int i = 0; i < n; i++) check({req, " chan"}, log_ch[base + i], exp_ch[i]);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int b, n;
    void'($urandom(32'd4242));
    idle(4);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    check("R1 status", status, 0);
    check("R1 irq", irq, 0);
    check("R1 start", conv_start, 0);
    check("R1 reg_data", reg_data, 0);
    check("R1 inj_data", inj_data, 0);
    idle(5);
    check("R1 no issue", n_log, 0);

    // R2 scan off: only rank 0
    wr(A_REG + 0, 5); wr(A_REG + 1, 7); wr(A_REG + 2, 8);
    wr(A_LEN, 2);
    b = n_log;
    wr(A_CTRL, SWR);
    idle(30);
    exp_ch[0] = 5;
    chk_seq("R2", b, 1);
    check("R2 data", reg_data, res(b, 5));
    check("R12 reg start flag", status[2], 1);
    check("R11 eoc", status[0], 1);

    // R3 full scan of 9 ranks, end-of-list flag mode
    for (int k = 0; k < 9; k++) begin
      exp_ch[k] = 5'($urandom % 12);
      wr(A_REG + k, int'(exp_ch[k]));
    end
    wr(A_LEN, 8);
    wr(A_STAT, 0);
    b = n_log;
    wr(A_CTRL, SCAN | SWR);
    idle(80);
    chk_seq("R3", b, 9);
    check("R3 data", reg_data, res(b + 8, exp_ch[8]));
    check("R11 no ovf in list mode", status[4], 0);
    wr(A_LEN, 15);   // out of range: ignored
    b = n_log;
    wr(A_CTRL, SCAN | SWR);
    idle(80);
    chk_seq("R3 bad length ignored", b, 9);
    check("R11 no ovf without dma", status[4], 0);
    wr(A_CTRL, SCAN | DMA | SWR);
    idle(80);
    check("R11 ovf with dma", status[4], 1);

    // R11 per-result flag mode
    wr(A_LEN, 2);
    wr(A_STAT, 0);
    b = n_log;
    wr(A_CTRL, SCAN | EOCE | SWR);
    idle(40);
    check("R11 per-result ovf", status[4], 1);
    check("R11 newest data kept", reg_data, res(b + 2, exp_ch[2]));

    // R4 inserted list of 2 uses slots 2,3
    wr(A_INJ + 0, 1); wr(A_INJ + 1, 2); wr(A_INJ + 2, 3); wr(A_INJ + 3, 4);
    wr(A_LEN, (1 << 4) | 2);
    wr(A_STAT, 0);
    b = n_log;
    wr(A_CTRL, SCAN | SWI);
    idle(30);
    exp_ch[0] = 3; exp_ch[1] = 4;
    chk_seq("R4", b, 2);
    check("R4 rank0 data", inj_data[15:0], res(b, 3));
    check("R4 rank1 data", inj_data[31:16], res(b + 1, 4));
    check("R4 eoi", status[1], 1);
    check("R12 inj start flag", status[3], 1);

    // R6 regular discontinuous: 7 ranks, chunk 3
    for (int k = 0; k < 7; k++) begin
      exp_ch[k] = 5'($urandom % 12);
      wr(A_REG + k, int'(exp_ch[k]));
    end
    wr(A_LEN, 6);
    wr(A_STAT, 0);
    b = n_log;
    wr(A_CTRL, SCAN | DREG | (2 << 7) | SWR);
    idle(40);
    check("R6 first chunk", n_log - b, 3);
    wr(A_CTRL, SCAN | DREG | (2 << 7) | SWR);
    idle(40);
    check("R6 second chunk", n_log - b, 6);
    check("R6 eoc not yet", status[0], 0);
    wr(A_CTRL, SCAN | DREG | (2 << 7) | SWR);
    idle(40);
    chk_seq("R6 tail", b, 7);
    check("R6 eoc at end", status[0], 1);

    // R7 inserted discontinuous: 3 ranks at slots 1..3
    wr(A_LEN, (2 << 4) | 6);
    wr(A_STAT, 0);
    b = n_log;
    for (int t = 0; t < 3; t++) begin
      wr(A_CTRL, SCAN | DINJ | SWI);
      idle(20);
      check("R7 one per launch", n_log - b, t + 1);
      check("R7 eoi only at end", status[1], (t == 2) ? 1 : 0);
    end
    exp_ch[0] = 2; exp_ch[1] = 3; exp_ch[2] = 4;
    chk_seq("R7", b, 3);

    // R8 continuous, then stop
    wr(A_REG + 0, 6); wr(A_REG + 1, 9);
    wr(A_LEN, 1);
    b = n_log;
    wr(A_CTRL, SCAN | CONT | SWR);
    idle(40);
    wr(A_CTRL, SCAN);
    idle(40);
    n = n_log - b;
    check("R8 restarted", (n >= 4) ? 1 : 0, 1);
    check("R8 stops at list end", n % 2, 0);
    for (int i = 0; i < n; i++) check("R8 order", log_ch[b + i], (i % 2 == 0) ? 6 : 9);
    idle(20);
    check("R8 stays stopped", n_log - b, n);

    // R9 auto-inserted after the regular list
    wr(A_INJ + 3, 11);
    wr(A_LEN, 1);
    wr(A_STAT, 0);
    b = n_log;
    wr(A_CTRL, SCAN | AUTO | SWR);
    idle(40);
    exp_ch[0] = 6; exp_ch[1] = 9; exp_ch[2] = 11;
    chk_seq("R9", b, 3);
    check("R9 eoi", status[1], 1);

    // R5 inserted launch inside a long regular conversion
    lat = 8;
    for (int k = 0; k < 4; k++) wr(A_REG + k, k + 1);
    wr(A_LEN, 3);
    b = n_log;
    wr(A_CTRL, SCAN | SWR);
    while (n_log < b + 1) @(negedge clk);
    wr(A_CTRL, SCAN | SWI);
    idle(80);
    exp_ch[0] = 1; exp_ch[1] = 11; exp_ch[2] = 2; exp_ch[3] = 3; exp_ch[4] = 4;
    chk_seq("R5", b, 5);
    lat = 2;

    // R10 edge modes, single rank, scan off
    wr(A_LEN, 0);
    b = n_log;
    wr(A_CTRL, 1 << 10);
    ext_trig_reg = 1; idle(15); check("R10 rise on rise", n_log - b, 1);
    ext_trig_reg = 0; idle(15); check("R10 rise on fall", n_log - b, 1);
    wr(A_CTRL, 2 << 10);
    ext_trig_reg = 1; idle(15); check("R10 fall on rise", n_log - b, 1);
    ext_trig_reg = 0; idle(15); check("R10 fall on fall", n_log - b, 2);
    wr(A_CTRL, 3 << 10);
    ext_trig_reg = 1; idle(15); check("R10 both on rise", n_log - b, 3);
    ext_trig_reg = 0; idle(15); check("R10 both on fall", n_log - b, 4);
    wr(A_CTRL, 0);
    ext_trig_reg = 1; idle(15);
    ext_trig_reg = 0; idle(15); check("R10 off", n_log - b, 4);
    wr(A_CTRL, 1 << 12);
    ext_trig_inj = 1; idle(15);
    check("R10 inserted rise", n_log - b, 5);
    check("R10 inserted chan", log_ch[b + 4], 11);
    ext_trig_inj = 0;

    // R13 clear by writing zero, interrupt gating
    idle(5);
    check("R13 irq gated off", irq, 0);
    wr(A_CTRL, 1 << 16);
    idle(3);
    check("R13 irq eoc", irq, 5'b00001);
    wr(A_STAT, 1);
    idle(2);
    check("R13 keep only bit0", status, 5'b00001);
    wr(A_STAT, 0);
    idle(3);
    check("R13 cleared", status, 0);
    check("R13 irq cleared", irq, 0);

    // R3 seeded random lists
    for (int r = 0; r < 8; r++) begin
      n = 1 + int'($urandom % 9);
      for (int k = 0; k < n; k++) begin
        exp_ch[k] = 5'($urandom % 12);
        wr(A_REG + k, int'(exp_ch[k]));
      end
      wr(A_LEN, n - 1);
      wr(A_STAT, 0);
      b = n_log;
      wr(A_CTRL, SCAN | SWR);
      idle(n * 8 + 20);
      chk_seq("R3 random", b, n);
      check("R3 random data", reg_data, res(b + n - 1, exp_ch[n - 1]));
      check("R11 random eoc", status[0], 1);
    end

    finish_run();
  end
endmodule